// File: doc/BRIEF.md
# Sector Erase Acceptance Timer

This block controls the short acceptance window in which a flash device collects sector-erase requests before it starts erasing. A command decoder upstream hands it one decoded event per cycle: a sector erase carrying a sector index, a chip erase, an erase suspend, or any other command. The first sector erase opens the window. Each further sector erase that arrives while the window is open adds its sector to a selection bitmap and restarts the full timeout.

When the timeout runs out without a new request, the block raises its erase-started status bit and issues a one-cycle start strobe to the erase engine, along with the bitmap. A chip erase skips the window entirely. After the erase has started, the block ignores every command except erase suspend. Erase suspend produces a one-cycle request to the engine, and the block then waits for a resume. The engine's done indication clears the selection and returns the block to idle.

The timeout is set in clock cycles. Its default is 50 µs at the configured clock frequency, which is the shortest gap between requests that must always be accepted.

Top module: `sect_erase_window`

## Requirements
- R1: After reset, erase_started, start_strobe and suspend_req are 0 and start_map is all zeros.
- R2: A sector erase (cmd_kind 2'b01) accepted in idle opens the window. erase_started stays 0 for the next TIMEOUT_CYCLES-1 cycles and becomes 1 in the TIMEOUT_CYCLES-th cycle if no further request arrives.
- R3: A sector erase accepted while the window is open sets start_map bit cmd_sector and restarts the full timeout from that cycle. Bits already selected are kept.
- R4: When the window times out, start_strobe is 1 for exactly one cycle, in the same cycle that erase_started rises. start_map then holds the OR of all selected sectors.
- R5: A chip erase (cmd_kind 2'b10) accepted in idle raises erase_started and start_strobe in the next cycle, with start_map all ones.
- R6: While erase_started is 1, sector-erase, chip-erase and other (cmd_kind 2'b00) commands leave start_map unchanged and produce no strobe.
- R7: A chip-erase or other command received while the window is open clears start_map and returns to idle without starting an erase.
- R8: An erase suspend (cmd_kind 2'b11) received after the erase has started gives a one-cycle suspend_req. Further suspends are ignored until resume is seen, after which a new suspend is honoured again.
- R9: engine_done, while the erase runs and is not suspended, drops erase_started, clears start_map and returns to idle, so a later sector erase opens a fresh window.
- R10: An erase suspend received while the window is open is ignored and does not restart the timeout.
- R11: In idle, other and erase-suspend commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 2 | 00 other, 01 sector erase, 10 chip erase, 11 erase suspend |
| cmd_sector | input | SECT_W | Sector index for a sector erase |
| resume | input | 1 | Resume event after a suspend |
| engine_done | input | 1 | Erase engine has finished |
| erase_started | output | 1 | Status bit: 0 while the window is open, 1 once the erase has begun |
| start_strobe | output | 1 | One-cycle start request to the erase engine |
| start_map | output | NUM_SECTORS | Selected-sector bitmap |
| suspend_req | output | 1 | One-cycle suspend request to the erase engine |

## Verification
The bench aims at the cycle where the timeout expires. It sends a request exactly on the last open cycle, which must restart the window rather than lose the sector; a design with an off-by-one counter would either start one cycle early or drop that sector. It also sends commands to a running erase to confirm they cannot change the bitmap or cause a second strobe. It checks that a suspend inside the window does not restart the timer, and that a second suspend while suspended makes no new request. A design that confused these cases would erase the wrong sectors, restart the engine, or hang waiting for the window to close.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER   = 2'b00,
    CMD_SECTOR  = 2'b01,
    CMD_CHIP    = 2'b10,
    CMD_SUSPEND = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_WINDOW = 2'b01,
    ST_BUSY   = 2'b10,
    ST_HELD   = 2'b11
  } win_state_e;
endpackage

// File: rtl/swin_timer.sv
module swin_timer #(
  parameter int TIMEOUT_CYCLES = 6250,
  parameter int CNT_W          = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (reload) begin
      cnt_d = CNT_W'(TIMEOUT_CYCLES);
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = reload | run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Last open cycle: the edge at the end of it closes the window
  assign expire = run && !reload && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/swin_sector_map.sv
module swin_sector_map #(
  parameter int NUM_SECTORS = 16,
  parameter int SECT_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   set_all,
  input  logic                   add_en,
  input  logic [SECT_W-1:0]      add_idx,
  output logic [NUM_SECTORS-1:0] map_q
);
  logic [NUM_SECTORS-1:0] hit;
  logic [NUM_SECTORS-1:0] map_d;
  logic                   map_en;

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_dec
    assign hit[i] = add_en && (add_idx == SECT_W'(i));
  end

  always_comb begin
    if (clr) begin
      map_d = '0;
    end else if (set_all) begin
      map_d = '1;
    end else begin
      map_d = map_q | hit;
    end
  end

  assign map_en = clr | set_all | add_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/swin_fsm.sv
module swin_fsm
  import swin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic       resume,
  input  logic       engine_done,
  input  logic       expire,
  output logic       reload,
  output logic       run,
  output logic       add_en,
  output logic       clr,
  output logic       set_all,
  output logic       erase_started,
  output logic       start_strobe,
  output logic       suspend_req
);
  win_state_e st_q, st_d;
  cmd_kind_e  kind;
  logic       strobe_d, susp_d;
  logic       is_sect, is_chip, is_other, is_susp;

  assign kind     = cmd_kind_e'(cmd_kind);
  assign is_sect  = cmd_valid && (kind == CMD_SECTOR);
  assign is_chip  = cmd_valid && (kind == CMD_CHIP);
  assign is_other = cmd_valid && (kind == CMD_OTHER);
  assign is_susp  = cmd_valid && (kind == CMD_SUSPEND);

  always_comb begin
    st_d     = st_q;
    reload   = 1'b0;
    add_en   = 1'b0;
    clr      = 1'b0;
    set_all  = 1'b0;
    strobe_d = 1'b0;
    susp_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (is_sect) begin
          add_en = 1'b1;
          reload = 1'b1;
          st_d   = ST_WINDOW;
        end else if (is_chip) begin
          set_all  = 1'b1;
          strobe_d = 1'b1;
          st_d     = ST_BUSY;
        end
      end
      ST_WINDOW: begin
        if (is_sect) begin
          add_en = 1'b1;
          reload = 1'b1;
        end else if (is_other || is_chip) begin
          clr  = 1'b1;
          st_d = ST_IDLE;
        end else if (expire) begin
          strobe_d = 1'b1;
          st_d     = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (engine_done) begin
          clr  = 1'b1;
          st_d = ST_IDLE;
        end else if (is_susp) begin
          susp_d = 1'b1;
          st_d   = ST_HELD;
        end
      end
      ST_HELD: begin
        if (resume) begin
          st_d = ST_BUSY;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      start_strobe <= 1'b0;
      suspend_req  <= 1'b0;
    end else begin
      st_q         <= st_d;
      start_strobe <= strobe_d;
      suspend_req  <= susp_d;
    end
  end

  assign run           = (st_q == ST_WINDOW);
  assign erase_started = (st_q == ST_BUSY) || (st_q == ST_HELD);
endmodule

// File: rtl/sect_erase_window.sv
module sect_erase_window #(
  parameter int NUM_SECTORS    = 16,
  parameter int CLK_MHZ        = 125,
  parameter int WINDOW_US      = 50,
  parameter int TIMEOUT_CYCLES = CLK_MHZ * WINDOW_US,
  localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int CNT_W  = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_kind,
  input  logic [SECT_W-1:0]      cmd_sector,
  input  logic                   resume,
  input  logic                   engine_done,
  output logic                   erase_started,
  output logic                   start_strobe,
  output logic [NUM_SECTORS-1:0] start_map,
  output logic                   suspend_req
);
  logic reload, run, expire, add_en, clr, set_all;

  swin_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_kind      (cmd_kind),
    .resume        (resume),
    .engine_done   (engine_done),
    .expire        (expire),
    .reload        (reload),
    .run           (run),
    .add_en        (add_en),
    .clr           (clr),
    .set_all       (set_all),
    .erase_started (erase_started),
    .start_strobe  (start_strobe),
    .suspend_req   (suspend_req)
  );

  swin_timer #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .CNT_W          (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .run    (run),
    .expire (expire)
  );

  swin_sector_map #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .set_all (set_all),
    .add_en  (add_en),
    .add_idx (cmd_sector),
    .map_q   (start_map)
  );
endmodule

// File: rtl/swin_checker.sv
module swin_checker #(
  parameter int NUM_SECTORS = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   erase_started,
  input logic                   start_strobe,
  input logic [NUM_SECTORS-1:0] start_map,
  input logic                   suspend_req
);
  // R4: a strobe only accompanies the rise of the status bit
  p_strobe_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> $rose(erase_started));

  // R4: every rise of the status bit carries a strobe
  p_rise_has_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_started) |-> start_strobe);

  // R4: the engine is never started with an empty selection
  p_map_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> (start_map != '0));

  // R6: the selection is frozen while the erase runs
  p_map_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_started && $past(erase_started)) |-> $stable(start_map));

  // R8: suspend request lasts one cycle
  p_susp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |=> !suspend_req);

  // R8: suspend request only once the erase has begun
  p_susp_started_r8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> erase_started);

  // R9: leaving the erase clears the selection
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_started) |-> (start_map == '0));
endmodule

bind sect_erase_window swin_checker #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .erase_started (erase_started),
  .start_strobe  (start_strobe),
  .start_map     (start_map),
  .suspend_req   (suspend_req)
);

// File: tb/tb_sect_erase_window.sv
module tb_sect_erase_window;
  localparam int NS = 16;
  localparam int T  = 20;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_kind;
  logic [SW-1:0] cmd_sector;
  logic          resume;
  logic          engine_done;
  logic          erase_started;
  logic          start_strobe;
  logic [NS-1:0] start_map;
  logic          suspend_req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state: 0 idle, 1 window, 2 busy, 3 suspended
  int          m_st = 0;
  int          m_cnt = 0;
  logic [NS-1:0] m_map = '0;
  logic        m_strobe = 1'b0;
  logic        m_susp = 1'b0;

  always #4 clk = ~clk;

  sect_erase_window #(.NUM_SECTORS(NS), .TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector), .resume(resume), .engine_done(engine_done),
    .erase_started(erase_started), .start_strobe(start_strobe),
    .start_map(start_map), .suspend_req(suspend_req));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model(input logic v, input logic [1:0] k, input int sec,
                                input logic rs, input logic dn);
    logic ns = 1'b0;
    logic nsp = 1'b0;
    case (m_st)
      0: if (v && k == 2'b01) begin
           m_map = '0; m_map[sec] = 1'b1; m_cnt = T; m_st = 1;
         end else if (v && k == 2'b10) begin
           m_map = '1; m_st = 2; ns = 1'b1;
         end
      1: if (v && k == 2'b01) begin
           m_map[sec] = 1'b1; m_cnt = T;
         end else if (v && (k == 2'b00 || k == 2'b10)) begin
           m_map = '0; m_st = 0;
         end else if (m_cnt == 1) begin
           m_st = 2; ns = 1'b1;
         end else begin
           m_cnt--;
         end
      2: if (dn) begin
           m_map = '0; m_st = 0;
         end else if (v && k == 2'b11) begin
           m_st = 3; nsp = 1'b1;
         end
      default: if (rs) m_st = 2;
    endcase
    m_strobe = ns;
    m_susp   = nsp;
  endfunction

  task automatic compare(input string tag);
    chk(64'(erase_started), 64'(m_st >= 2), tag, "erase_started");
    chk(64'(start_strobe), 64'(m_strobe), tag, "start_strobe");
    chk(64'(start_map), 64'(m_map), tag, "start_map");
    chk(64'(suspend_req), 64'(m_susp), tag, "suspend_req");
  endtask

  task automatic step(input logic v, input logic [1:0] k, input int sec,
                      input logic rs, input logic dn, input string tag);
    cmd_valid = v; cmd_kind = k; cmd_sector = SW'(sec); resume = rs; engine_done = dn;
    model(v, k, sec, rs, dn);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 0, 1'b0, 1'b0, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 2'b00; cmd_sector = '0;
    resume = 1'b0; engine_done = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle(2, "R1");

    // R11: other and suspend ignored in idle
    step(1'b1, 2'b00, 0, 1'b0, 1'b0, "R11");
    step(1'b1, 2'b11, 0, 1'b0, 1'b0, "R11");

    // R2 / R4: single sector, full window
    step(1'b1, 2'b01, 3, 1'b0, 1'b0, "R2");
    idle(T - 1, "R2");
    chk(64'(erase_started), 64'd0, "R2", "still open on last cycle");
    idle(1, "R4");
    chk(64'(start_strobe), 64'd1, "R4", "strobe at expiry");
    chk(64'(start_map), 64'h8, "R4", "map at expiry");
    idle(1, "R4");
    // R9: done returns to idle
    step(1'b0, 2'b00, 0, 1'b0, 1'b1, "R9");
    chk(64'(start_map), 64'd0, "R9", "map cleared");

    // R3: restart on the last open cycle
    step(1'b1, 2'b01, 1, 1'b0, 1'b0, "R3");
    idle(T - 1, "R3");
    step(1'b1, 2'b01, 5, 1'b0, 1'b0, "R3");
    idle(T - 1, "R3");
    chk(64'(erase_started), 64'd0, "R3", "restarted window");
    idle(1, "R3");
    chk(64'(start_map), 64'h22, "R3", "accumulated map");

    // R6: commands ignored while running
    step(1'b1, 2'b01, 7, 1'b0, 1'b0, "R6");
    step(1'b1, 2'b10, 0, 1'b0, 1'b0, "R6");
    step(1'b1, 2'b00, 0, 1'b0, 1'b0, "R6");
    chk(64'(start_map), 64'h22, "R6", "map frozen");
    // R8: suspend, repeat suspend, resume, suspend again
    step(1'b1, 2'b11, 0, 1'b0, 1'b0, "R8");
    chk(64'(suspend_req), 64'd1, "R8", "suspend pulse");
    step(1'b1, 2'b11, 0, 1'b0, 1'b0, "R8");
    chk(64'(suspend_req), 64'd0, "R8", "no second pulse");
    step(1'b0, 2'b00, 0, 1'b0, 1'b1, "R8");
    step(1'b0, 2'b00, 0, 1'b1, 1'b0, "R8");
    step(1'b1, 2'b11, 0, 1'b0, 1'b0, "R8");
    step(1'b0, 2'b00, 0, 1'b1, 1'b0, "R8");
    step(1'b0, 2'b00, 0, 1'b0, 1'b1, "R9");

    // R7: abort by other and by chip erase
    step(1'b1, 2'b01, 2, 1'b0, 1'b0, "R7");
    idle(4, "R7");
    step(1'b1, 2'b00, 0, 1'b0, 1'b0, "R7");
    chk(64'(start_map), 64'd0, "R7", "abort by other");
    idle(T + 2, "R7");
    step(1'b1, 2'b01, 9, 1'b0, 1'b0, "R7");
    step(1'b1, 2'b10, 0, 1'b0, 1'b0, "R7");
    idle(T + 2, "R7");
    chk(64'(erase_started), 64'd0, "R7", "abort by chip");

    // R5: chip erase from idle
    step(1'b1, 2'b10, 0, 1'b0, 1'b0, "R5");
    chk(64'(start_strobe), 64'd1, "R5", "chip strobe");
    chk(64'(start_map), 64'hFFFF, "R5", "chip map");
    step(1'b0, 2'b00, 0, 1'b0, 1'b1, "R9");

    // R10: suspend in window does not restart the timer
    step(1'b1, 2'b01, 15, 1'b0, 1'b0, "R10");
    idle(5, "R10");
    step(1'b1, 2'b11, 0, 1'b0, 1'b0, "R10");
    idle(T - 7, "R10");
    chk(64'(erase_started), 64'd0, "R10", "before expiry");
    idle(1, "R10");
    chk(64'(erase_started), 64'd1, "R10", "expiry not delayed");
    step(1'b0, 2'b00, 0, 1'b0, 1'b1, "R9");

    // constrained random
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      logic [1:0] k = 2'b00;
      logic v = 1'b1;
      string tag;
      if (r < 40) k = 2'b01;
      else if (r < 46) k = 2'b00;
      else if (r < 50) k = 2'b10;
      else if (r < 60) k = 2'b11;
      else v = 1'b0;
      case (m_st)
        0: tag = "R11";
        1: tag = "R3";
        2: tag = "R6";
        default: tag = "R8";
      endcase
      step(v, k, int'($urandom_range(0, NS - 1)),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 19) == 0), tag);
      if ($urandom_range(0, 15) == 0) idle(int'($urandom_range(0, T + 4)), "R2");
    end

    summary();
  end
endmodule